// File: doc/BRIEF.md
# Floating-Point Issue Interlock

This block is the decode-stage gate of an in-order pipeline that feeds three floating-point units and a short integer path. The units are an adder and a multiplier, both fully pipelined, and a divider that is not pipelined. Each cycle the block looks at one candidate instruction: which unit it needs, the register it will write and the two registers it reads. It then decides whether that instruction may leave decode in this cycle. It also raises a start pulse toward the selected unit.

The block refuses issue for four reasons:
- the divider is still occupied;
- the single register-file write port is already booked for the cycle in which this instruction would write back;
- a source register is still waiting on a result that has not yet been written;
- the destination is already the target of an instruction still in flight.

Write-port bookings are held in a reservation vector that moves one step toward "now" on every clock. Next to each booked slot sits the destination register that will be written in that slot. That table also serves as the record of pending destinations. An entry leaves the table when its write-back cycle passes, and the block reports that event on its write-back outputs. The candidate must be held steady by the fetch side until issue is granted, because issue is strictly in order.

Top module: `fp_issue_gate`

## Requirements
- R1: After reset no write-back is reported, no slot is booked and the divider is free, so a lone divide issues in the first cycle after reset.
- R2: With no hazard present, adder and multiplier operations (unit codes 1 and 2) issue in consecutive cycles, one per cycle. Integer operations (unit code 0) do the same.
- R3: A divide (unit code 3) issued in cycle t blocks any further divide until cycle t+25, in which it may issue.
- R4: An instruction whose write-back cycle (issue cycle plus latency: integer 1, adder 4, multiplier 7, divider 24) is already booked by an earlier instruction does not issue.
- R5: An instruction does not issue while either source register equals the destination of an in-flight instruction whose write-back lies after the current cycle. A source whose producer writes back in the current cycle is taken from the bypass and does not stall.
- R6: An instruction does not issue while its destination equals the destination of any in-flight instruction whose write-back lies after the current cycle.
- R7: Each issued instruction produces exactly one write-back report, in the cycle equal to its issue cycle plus its latency, carrying its destination register.
- R8: At most one start pulse is high in a cycle. It is high exactly when issue is granted, and it names the candidate's unit.
- R9: When a candidate is valid, exactly one of issue and stall is high. When no candidate is valid, both are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | A candidate instruction is present in decode |
| cand_unit | input | 2 | Unit class: 0 integer, 1 adder, 2 multiplier, 3 divider |
| cand_dst | input | REG_W | Destination register of the candidate |
| cand_src_a | input | REG_W | First source register |
| cand_src_b | input | REG_W | Second source register |
| issue | output | 1 | Candidate leaves decode this cycle |
| stall | output | 1 | Candidate is held in decode |
| start_int | output | 1 | Start pulse to the integer path |
| start_add | output | 1 | Start pulse to the adder |
| start_mul | output | 1 | Start pulse to the multiplier |
| start_div | output | 1 | Start pulse to the divider |
| wb_valid | output | 1 | A booked write-back takes the port this cycle |
| wb_dst | output | REG_W | Register written in this cycle's write-back |

## Verification
Faults in the reservation vector or the destination table are visible at the ports in two ways. A write-back report can come one slot early or late, or carry the wrong register. A candidate can also stall or issue when the cycle-accurate reference disagrees, which can happen as much as 24 cycles after the faulty issue. A wrong divider occupancy count shows up when the second divide of a pair issues one cycle early or late. The bench compares every output on every cycle. Because of that, a fault is reported in the first cycle in which it alters any port, whether it shows as a grant, a start pulse or a write-back report.

// File: rtl/fp_issue_pkg.sv
package fp_issue_pkg;

  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;

  // Cycles from issue to the write-back slot for each unit class.
  function automatic int unsigned lat_of(unit_e u, int unsigned l_int, int unsigned l_add,
                                         int unsigned l_mul, int unsigned l_div);
    case (u)
      UNIT_INT: lat_of = l_int;
      UNIT_ADD: lat_of = l_add;
      UNIT_MUL: lat_of = l_mul;
      default:  lat_of = l_div;
    endcase
  endfunction

  function automatic int unsigned max_of4(int unsigned a, int unsigned b, int unsigned c,
                                          int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    max_of4 = m;
  endfunction

endpackage

// File: rtl/wb_slot_tracker.sv
// Reservation vector for the write port plus the destination booked in each slot.
// Slot k describes the write-back that happens k cycles after the current one.
module wb_slot_tracker #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned HORIZON = 25,
  localparam int unsigned IDX_W  = $clog2(HORIZON + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            book,
  input  logic [IDX_W-1:0]                book_lat,
  input  logic [REG_W-1:0]                book_dst,
  output logic [HORIZON-1:0]              slot_busy,
  output logic [HORIZON-1:0][REG_W-1:0]   slot_dst
);

  for (genvar k = 0; k < HORIZON; k++) begin : g_slot
    logic             busy_q;
    logic [REG_W-1:0] dst_q;
    logic             take;
    logic             busy_in;
    logic [REG_W-1:0] dst_in;

    // Booking with latency k+1 lands in slot k after this edge's shift.
    assign take = book && (book_lat == IDX_W'(k + 1));

    if (k == HORIZON - 1) begin : g_top
      assign busy_in = 1'b0;
      assign dst_in  = '0;
    end else begin : g_mid
      assign busy_in = slot_busy[k+1];
      assign dst_in  = slot_dst[k+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        dst_q  <= '0;
      end else if (take) begin
        busy_q <= 1'b1;
        dst_q  <= book_dst;
      end else begin
        busy_q <= busy_in;
        dst_q  <= busy_in ? dst_in : '0;
      end
    end

    assign slot_busy[k] = busy_q;
    assign slot_dst[k]  = dst_q;
  end

endmodule

// File: rtl/div_occupancy.sv
// Counts down the initiation interval of the unpipelined divider.
module div_occupancy #(
  parameter int unsigned DIV_II = 25,
  localparam int unsigned CNT_W = $clog2(DIV_II + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              left_q <= '0;
    else if (start)          left_q <= CNT_W'(DIV_II - 1);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

endmodule

// File: rtl/hazard_scan.sv
// Compares the candidate registers against every destination still ahead of write-back.
module hazard_scan #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned HORIZON = 25
) (
  input  logic [HORIZON-1:0]            slot_busy,
  input  logic [HORIZON-1:0][REG_W-1:0] slot_dst,
  input  logic [REG_W-1:0]              dst,
  input  logic [REG_W-1:0]              src_a,
  input  logic [REG_W-1:0]              src_b,
  output logic                          raw_hit,
  output logic                          waw_hit
);

  logic [HORIZON-1:0] raw_v;
  logic [HORIZON-1:0] waw_v;

  // Slot 0 writes this cycle: its value is bypassed and its order is already safe.
  assign raw_v[0] = 1'b0;
  assign waw_v[0] = 1'b0;

  for (genvar k = 1; k < HORIZON; k++) begin : g_cmp
    assign raw_v[k] = slot_busy[k] && ((slot_dst[k] == src_a) || (slot_dst[k] == src_b));
    assign waw_v[k] = slot_busy[k] && (slot_dst[k] == dst);
  end

  assign raw_hit = |raw_v;
  assign waw_hit = |waw_v;

endmodule

// File: rtl/fp_issue_gate.sv
module fp_issue_gate
  import fp_issue_pkg::*;
#(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned LAT_INT = 1,
  parameter int unsigned LAT_ADD = 4,
  parameter int unsigned LAT_MUL = 7,
  parameter int unsigned LAT_DIV = 24,
  localparam int unsigned DIV_II  = LAT_DIV + 1,
  localparam int unsigned HORIZON = max_of4(LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV) + 1,
  localparam int unsigned IDX_W   = $clog2(HORIZON + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cand_valid,
  input  logic [1:0]       cand_unit,
  input  logic [REG_W-1:0] cand_dst,
  input  logic [REG_W-1:0] cand_src_a,
  input  logic [REG_W-1:0] cand_src_b,
  output logic             issue,
  output logic             stall,
  output logic             start_int,
  output logic             start_add,
  output logic             start_mul,
  output logic             start_div,
  output logic             wb_valid,
  output logic [REG_W-1:0] wb_dst
);

  unit_e                          unit;
  logic [IDX_W-1:0]               cand_lat;
  logic [HORIZON-1:0]             slot_busy;
  logic [HORIZON-1:0][REG_W-1:0]  slot_dst;
  logic                           div_busy;

  // Named hazard events, observed by the bound checker.
  logic haz_div;
  logic haz_port;
  logic haz_raw;
  logic haz_waw;
  logic haz_any;

  assign unit     = unit_e'(cand_unit);
  assign cand_lat = IDX_W'(lat_of(unit, LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV));

  wb_slot_tracker #(.REG_W(REG_W), .HORIZON(HORIZON)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .book      (issue),
    .book_lat  (cand_lat),
    .book_dst  (cand_dst),
    .slot_busy (slot_busy),
    .slot_dst  (slot_dst)
  );

  div_occupancy #(.DIV_II(DIV_II)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_div),
    .busy  (div_busy)
  );

  hazard_scan #(.REG_W(REG_W), .HORIZON(HORIZON)) u_scan (
    .slot_busy (slot_busy),
    .slot_dst  (slot_dst),
    .dst       (cand_dst),
    .src_a     (cand_src_a),
    .src_b     (cand_src_b),
    .raw_hit   (haz_raw),
    .waw_hit   (haz_waw)
  );

  assign haz_div  = (unit == UNIT_DIV) && div_busy;
  assign haz_port = slot_busy[cand_lat];
  assign haz_any  = haz_div || haz_port || haz_raw || haz_waw;

  assign issue     = cand_valid && !haz_any;
  assign stall     = cand_valid && haz_any;
  assign start_int = issue && (unit == UNIT_INT);
  assign start_add = issue && (unit == UNIT_ADD);
  assign start_mul = issue && (unit == UNIT_MUL);
  assign start_div = issue && (unit == UNIT_DIV);

  assign wb_valid = slot_busy[0];
  assign wb_dst   = slot_dst[0];

endmodule

// File: rtl/fp_issue_gate_chk.sv
module fp_issue_gate_chk #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DIV_II = 25,
  localparam int unsigned CNT_W = $clog2(DIV_II + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cand_valid,
  input logic [1:0]       cand_unit,
  input logic [REG_W-1:0] cand_dst,
  input logic             issue,
  input logic             stall,
  input logic             start_int,
  input logic             start_add,
  input logic             start_mul,
  input logic             start_div,
  input logic             wb_valid,
  input logic [REG_W-1:0] wb_dst,
  input logic             haz_div,
  input logic             haz_port,
  input logic             haz_raw,
  input logic             haz_waw
);

  // Independent count of cycles since the last divide start.
  logic [CNT_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n)             gap_q <= '0;
    else if (start_div)     gap_q <= CNT_W'(DIV_II - 1);
    else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
  end

  a_r9_issue_xor_stall: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (issue ^ stall));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_valid |-> (!issue && !stall));

  a_r8_one_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_int, start_add, start_mul, start_div}) &&
    (issue == (start_int || start_add || start_mul || start_div)));

  a_r3_div_gap: assert property (@(posedge clk) disable iff (!rst_n)
    start_div |-> (gap_q == '0));

  a_r2_free_add: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_unit == 2'd1 && !haz_port && !haz_raw && !haz_waw) |-> issue);

  a_r4_port_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    haz_port |-> !issue);

  a_r5_raw_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    haz_raw |-> !issue);

  a_r6_waw_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && haz_waw) |-> stall);

  a_r3_div_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    haz_div |-> !start_div);

  a_r7_int_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    start_int |=> (wb_valid && wb_dst == $past(cand_dst)));

endmodule

bind fp_issue_gate fp_issue_gate_chk #(.REG_W(REG_W), .DIV_II(DIV_II)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cand_valid (cand_valid),
  .cand_unit  (cand_unit),
  .cand_dst   (cand_dst),
  .issue      (issue),
  .stall      (stall),
  .start_int  (start_int),
  .start_add  (start_add),
  .start_mul  (start_mul),
  .start_div  (start_div),
  .wb_valid   (wb_valid),
  .wb_dst     (wb_dst),
  .haz_div    (haz_div),
  .haz_port   (haz_port),
  .haz_raw    (haz_raw),
  .haz_waw    (haz_waw)
);

// File: tb/test_fp_issue_gate.sv
module test_fp_issue_gate;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cand_valid = 1'b0;
  logic [1:0]    cand_unit = 2'd0;
  logic [RW-1:0] cand_dst = '0;
  logic [RW-1:0] cand_src_a = '0;
  logic [RW-1:0] cand_src_b = '0;
  logic          issue, stall, start_int, start_add, start_mul, start_div;
  logic          wb_valid;
  logic [RW-1:0] wb_dst;

  fp_issue_gate i_fp_issue_gate (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_unit(cand_unit),
    .cand_dst(cand_dst), .cand_src_a(cand_src_a), .cand_src_b(cand_src_b),
    .issue(issue), .stall(stall), .start_int(start_int), .start_add(start_add),
    .start_mul(start_mul), .start_div(start_div), .wb_valid(wb_valid), .wb_dst(wb_dst)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails = 0;

  // Reference: list of in-flight writes (register, absolute write-back cycle).
  int pend_w[$];
  int pend_d[$];
  int now_c = 0;
  int div_free_at = 0;

  function automatic int latency(int u);
    case (u)
      0: return 1;
      1: return 4;
      2: return 7;
      default: return 24;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, now_c, act, exp);
    end
  endtask

  // One clock: present a candidate, compare all outputs, advance the reference.
  task automatic step(input bit v, input int u, input int d, input int a, input int b,
                      output bit granted);
    bit hd, hp, hr, hw, exp_iss, exp_wbv;
    int exp_wbd, lat;
    string tag;
    @(negedge clk);
    cand_valid = v; cand_unit = 2'(u); cand_dst = RW'(d);
    cand_src_a = RW'(a); cand_src_b = RW'(b);
    #1;
    lat = latency(u);
    hd = (u == 3) && (now_c < div_free_at);
    hp = 0; hr = 0; hw = 0; exp_wbv = 0; exp_wbd = 0;
    foreach (pend_w[i]) begin
      if (pend_w[i] == now_c + lat) hp = 1;
      if (pend_w[i] > now_c && (pend_d[i] == a || pend_d[i] == b)) hr = 1;
      if (pend_w[i] > now_c && pend_d[i] == d) hw = 1;
      if (pend_w[i] == now_c) begin exp_wbv = 1; exp_wbd = pend_d[i]; end
    end
    exp_iss = v && !(hd || hp || hr || hw);
    if (hd) tag = "R3 divider busy";
    else if (hp) tag = "R4 write port";
    else if (hr) tag = "R5 raw";
    else if (hw) tag = "R6 waw";
    else tag = "R2 issue";
    check(tag, int'(issue), int'(exp_iss));
    check("R9 stall", int'(stall), int'(v && !exp_iss));
    check("R8 start pulses", int'({start_div, start_mul, start_add, start_int}),
          exp_iss ? (1 << u) : 0);
    check("R7 wb valid", int'(wb_valid), int'(exp_wbv));
    if (exp_wbv) check("R7 wb dst", int'(wb_dst), exp_wbd);
    granted = exp_iss;
    @(posedge clk);
    if (exp_iss) begin
      pend_w.push_back(now_c + lat);
      pend_d.push_back(d);
      if (u == 3) div_free_at = now_c + 25;
    end
    now_c++;
    for (int i = pend_w.size() - 1; i >= 0; i--)
      if (pend_w[i] < now_c) begin pend_w.delete(i); pend_d.delete(i); end
  endtask

  // In-order issue: hold the candidate until granted; return cycles spent waiting.
  task automatic send(input int u, input int d, input int a, input int b, output int waited);
    bit g;
    waited = 0;
    g = 0;
    while (!g) begin
      step(1, u, d, a, b, g);
      if (!g) waited++;
    end
  endtask

  task automatic idle(input int n);
    bit g;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, g);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, expected completion");
    finish_run();
  end

  initial begin
    int w;
    bit g;
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset leaves nothing booked and the divider free.
    check("R1 no wb after reset", int'(wb_valid), 0);
    send(3, 9, 1, 2, w);
    check("R1 divide issues at once", w, 0);
    idle(30);

    // R2: back-to-back adds and multiplies with distinct registers.
    send(1, 1, 20, 21, w); check("R2 add", w, 0);
    send(2, 2, 20, 21, w); check("R2 mul", w, 0);
    send(1, 3, 20, 21, w); check("R2 add", w, 0);
    send(2, 4, 20, 21, w); check("R2 mul", w, 0);
    idle(10);

    // R5: dependent add waits until the producer writes back (bypass in that cycle).
    send(1, 5, 20, 21, w);
    send(1, 6, 5, 21, w);
    check("R5 raw wait cycles", w, 3);
    idle(10);

    // R6: multiply then add to the same register.
    send(2, 7, 20, 21, w);
    send(1, 7, 22, 23, w);
    check("R6 waw wait cycles", w, 6);
    idle(10);

    // R4: multiply, two fillers, then an add hitting the same write slot.
    send(2, 10, 20, 21, w);
    send(0, 11, 20, 21, w);
    send(0, 12, 20, 21, w);
    send(1, 13, 20, 21, w);
    check("R4 port conflict wait", w, 1);
    idle(10);

    // R4: integer op colliding with an add's write-back.
    send(1, 14, 20, 21, w);
    send(0, 15, 20, 21, w);
    send(0, 16, 20, 21, w);
    send(0, 17, 20, 21, w);
    check("R4 int vs add wait", w, 1);
    idle(10);

    // R3: two divides in a row, the second waits 24 cycles.
    send(3, 18, 20, 21, w);
    send(3, 19, 20, 21, w);
    check("R3 divide gap wait", w, 24);
    idle(30);

    // Mixed traffic over a small register set to provoke every hazard kind.
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[15:13] == 3'd0) idle(1);
      else send(((lfsr[2:0] == 3'd7) ? 3 : int'(lfsr[4:3]) % 3),
                int'(lfsr[7:5]), int'(lfsr[10:8]), int'(lfsr[13:11]), w);
    end
    idle(30);
    step(0, 0, 0, 0, 0, g);
    check("R9 idle no stall", int'(stall), 0);
    finish_run();
  end

endmodule